// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit IEEE-754 single-precision operand and produces the 16-bit half-precision value nearest to it. Rounding is always round-to-nearest with ties broken toward an even last bit. It produces subnormal half-precision results by gradual underflow and never flushes them to zero. It reports four exception flags with each result: invalid operation, overflow, underflow and inexact.

A caller presents an operand with a valid strobe and a mode bit. The mode bit selects whether NaN inputs are replaced by one canonical NaN or keep part of their payload. The result and flags appear one clock later with their own valid strobe. The output registers keep their values until the next accepted operand. Operands may arrive on every cycle.

Top module: `f32_to_f16_narrow`

## Requirements
- R1: `res_vld` is high exactly one cycle after each cycle in which `op_vld` is high, and low otherwise. While `op_vld` is low, `res_word` and the flags keep their previous values. After reset `res_vld` is 0.
- R2: A zero input (exponent field 0, fraction 0) gives a half zero of the same sign. An infinite input (exponent 255, fraction 0) gives a half infinity of the same sign (0x7C00 or 0xFC00). Neither raises a flag.
- R3: With `dflt_nan` high, every NaN input (exponent 255, fraction nonzero) gives exactly 0x7E00, whatever its sign and payload.
- R4: With `dflt_nan` low, a NaN gives sign bit equal to input bit 31, exponent field all ones, fraction equal to input fraction bits 22 to 13, and bit 9 forced to 1.
- R5: `flg_invalid` is raised for a signalling NaN (input bit 22 clear). It is raised in both NaN modes. No other input raises it.
- R6: Normal results round to nearest with ties to even. `flg_inexact` is raised when any discarded bit is nonzero.
- R7: A rounding increment that carries out of the 10-bit fraction raises the exponent by one. For example, 0x3FFFF000 gives 0x4000.
- R8: A result whose rounded magnitude exceeds 65504 becomes a signed infinity and raises both overflow and inexact. 65504 itself converts exactly.
- R9: Inputs below 2^-14 in magnitude give correctly rounded half subnormals. All bits shifted out take part in the sticky bit. The largest subnormal may round up to 0x0400.
- R10: `flg_underflow` is raised when the input magnitude is below 2^-14 before rounding and the result is inexact. Exact subnormal results do not raise it.
- R11: A nonzero input that rounds to nothing gives a zero of the input's sign, with underflow and inexact raised.
- R12: A single-precision subnormal input gives a zero of its sign, with underflow and inexact raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operand valid strobe |
| op_word | input | 32 | Single-precision operand |
| dflt_nan | input | 1 | 1: NaNs become 0x7E00; 0: NaN payload is truncated |
| res_vld | output | 1 | Result valid, one cycle after `op_vld` |
| res_word | output | 16 | Half-precision result |
| flg_invalid | output | 1 | Signalling NaN seen |
| flg_overflow | output | 1 | Result overflowed to infinity |
| flg_underflow | output | 1 | Tiny and inexact result |
| flg_inexact | output | 1 | Result differs from the operand |

## Verification
The hardest cases to reach are exact ties and near-ties below 2^-14. There the shift into the subnormal range moves the guard position, and a single far-off bit decides the rounding. Uniform random words almost never land there, because only a narrow band of exponent codes maps to half subnormals. The stimulus therefore concentrates random exponents around the half-precision range and often forces the discarded bits to a bare halfway pattern. Directed vectors cover the carry from the largest subnormal into the smallest normal and the carry just above 65504.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SRC_EW    = 8;
  localparam int SRC_FW    = 23;
  localparam int SRC_W     = 1 + SRC_EW + SRC_FW;
  localparam int DST_EW    = 5;
  localparam int DST_FW    = 10;
  localparam int DST_W     = 1 + DST_EW + DST_FW;
  localparam int SRC_BIAS  = (1 << (SRC_EW - 1)) - 1;
  localparam int DST_BIAS  = (1 << (DST_EW - 1)) - 1;
  localparam int REBIAS    = SRC_BIAS - DST_BIAS;
  localparam int FW_GAP    = SRC_FW - DST_FW;
  localparam int SIG_W     = SRC_FW + 1;
  localparam int WIDE_W    = 2 * SIG_W;
  localparam int SH_CLAMP  = SRC_FW + 2;
  localparam int SH_W      = $clog2(SH_CLAMP + 1);
  localparam int EH_W      = SRC_EW + 2;
  localparam int DST_EMAX  = (1 << DST_EW) - 1;
  localparam int FLAG_W    = 4;

  localparam logic [DST_W-1:0] DFLT_NAN_WORD =
    {1'b0, {DST_EW{1'b1}}, 1'b1, {(DST_FW-1){1'b0}}};

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SRC_SUB,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } f2h_cls_e;

  typedef struct packed {
    logic              sgn;
    f2h_cls_e          cls;
    logic [SRC_EW-1:0] exp;
    logic [SRC_FW-1:0] frac;
  } f2h_dec_t;

  typedef struct packed {
    logic              tiny;
    logic              huge;
    logic [DST_EW-1:0] bexp;
    logic [DST_FW-1:0] frac;
    logic              guard;
    logic              sticky;
  } f2h_grs_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } f2h_flags_t;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [SRC_W-1:0] word_i,
  output f2h_dec_t         dec_o
);
  logic              sgn;
  logic [SRC_EW-1:0] exp;
  logic [SRC_FW-1:0] frac;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;

  assign sgn       = word_i[SRC_W-1];
  assign exp       = word_i[SRC_W-2 -: SRC_EW];
  assign frac      = word_i[SRC_FW-1:0];
  assign exp_zero  = (exp == '0);
  assign exp_ones  = (exp == '1);
  assign frac_zero = (frac == '0);

  always_comb begin
    dec_o.sgn  = sgn;
    dec_o.exp  = exp;
    dec_o.frac = frac;
    if (exp_zero) begin
      dec_o.cls = frac_zero ? CLS_ZERO : CLS_SRC_SUB;
    end else if (exp_ones) begin
      if (frac_zero)             dec_o.cls = CLS_INF;
      else if (frac[SRC_FW-1])   dec_o.cls = CLS_QNAN;
      else                       dec_o.cls = CLS_SNAN;
    end else begin
      dec_o.cls = CLS_FINITE;
    end
  end
endmodule

// File: rtl/f2h_align.sv
module f2h_align
  import f2h_pkg::*;
(
  input  logic [SRC_EW-1:0] exp_i,
  input  logic [SRC_FW-1:0] frac_i,
  output f2h_grs_t          grs_o
);
  logic [EH_W-1:0]   eh;
  logic [EH_W-1:0]   sh_full;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;
  logic              tiny;
  logic              huge;

  // Half-precision biased exponent, two's complement; <= 0 means tiny.
  assign eh      = EH_W'(exp_i) - EH_W'(REBIAS);
  assign tiny    = eh[EH_W-1] | (eh == '0);
  assign huge    = !eh[EH_W-1] && (eh >= EH_W'(DST_EMAX));
  assign sh_full = EH_W'(FW_GAP + 1) - eh;
  assign sh      = (sh_full > EH_W'(SH_CLAMP)) ? SH_W'(SH_CLAMP) : sh_full[SH_W-1:0];
  assign wide    = {1'b1, frac_i, {SIG_W{1'b0}}} >> sh;

  always_comb begin
    grs_o.tiny = tiny;
    grs_o.huge = huge;
    if (tiny) begin
      grs_o.bexp   = '0;
      grs_o.frac   = wide[SIG_W+DST_FW-1:SIG_W];
      grs_o.guard  = wide[SIG_W-1];
      grs_o.sticky = |wide[SIG_W-2:0];
    end else begin
      grs_o.bexp   = eh[DST_EW-1:0];
      grs_o.frac   = frac_i[SRC_FW-1 -: DST_FW];
      grs_o.guard  = frac_i[FW_GAP-1];
      grs_o.sticky = |frac_i[FW_GAP-2:0];
    end
  end

  // R9: the subnormal shift leaves no integer bits above the fraction field
  always_comb begin
    assert_align_headroom_R9: assert (!tiny || wide[WIDE_W-1:SIG_W+DST_FW] == '0);
    assert_align_excl_R8: assert (!(tiny && huge));
  end
endmodule

// File: rtl/f2h_round_pack.sv
module f2h_round_pack
  import f2h_pkg::*;
(
  input  logic              sgn_i,
  input  f2h_cls_e          cls_i,
  input  logic [DST_FW-1:0] nan_pay_i,
  input  f2h_grs_t          grs_i,
  input  logic              dflt_nan_i,
  output logic [DST_W-1:0]  word_o,
  output f2h_flags_t        flags_o
);
  logic                  inc;
  logic                  lost;
  logic [DST_W-2:0]      sum;
  logic                  ovf;
  logic [DST_W-2:0]      inf_mag;

  assign inf_mag = {{DST_EW{1'b1}}, {DST_FW{1'b0}}};
  assign lost    = grs_i.guard | grs_i.sticky;
  assign inc     = grs_i.guard & (grs_i.sticky | grs_i.frac[0]);
  assign sum     = {grs_i.bexp, grs_i.frac} + (DST_W-1)'(inc);
  assign ovf     = grs_i.huge | (sum[DST_W-2 -: DST_EW] == '1);

  always_comb begin
    word_o  = {sgn_i, {(DST_W-1){1'b0}}};
    flags_o = '0;
    unique case (cls_i)
      CLS_ZERO: ;
      CLS_INF: word_o = {sgn_i, inf_mag};
      CLS_QNAN, CLS_SNAN: begin
        flags_o.invalid = (cls_i == CLS_SNAN);
        if (dflt_nan_i) word_o = DFLT_NAN_WORD;
        else begin
          word_o = {sgn_i, {DST_EW{1'b1}}, nan_pay_i};
          word_o[DST_FW-1] = 1'b1;
        end
      end
      CLS_SRC_SUB: begin
        flags_o.underflow = 1'b1;
        flags_o.inexact   = 1'b1;
      end
      CLS_FINITE: begin
        if (ovf) begin
          word_o           = {sgn_i, inf_mag};
          flags_o.overflow = 1'b1;
          flags_o.inexact  = 1'b1;
        end else begin
          word_o            = {sgn_i, sum};
          flags_o.inexact   = lost;
          flags_o.underflow = grs_i.tiny & lost;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/f32_to_f16_narrow.sv
module f32_to_f16_narrow
  import f2h_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [SRC_W-1:0] op_word,
  input  logic             dflt_nan,
  output logic             res_vld,
  output logic [DST_W-1:0] res_word,
  output logic             flg_invalid,
  output logic             flg_overflow,
  output logic             flg_underflow,
  output logic             flg_inexact
);
  f2h_dec_t         dec;
  f2h_grs_t         grs;
  logic [DST_W-1:0] cvt_word;
  f2h_flags_t       cvt_flags;

  logic             vld_q, vld_d;
  logic [DST_W-1:0] word_q, word_d;
  f2h_flags_t       flags_q, flags_d;

  f2h_classify u_classify (
    .word_i (op_word),
    .dec_o  (dec)
  );

  f2h_align u_align (
    .exp_i  (dec.exp),
    .frac_i (dec.frac),
    .grs_o  (grs)
  );

  f2h_round_pack u_round_pack (
    .sgn_i      (dec.sgn),
    .cls_i      (dec.cls),
    .nan_pay_i  (dec.frac[SRC_FW-1 -: DST_FW]),
    .grs_i      (grs),
    .dflt_nan_i (dflt_nan),
    .word_o     (cvt_word),
    .flags_o    (cvt_flags)
  );

  // next-state: data registers load only when an operand is accepted
  always_comb begin
    vld_d   = op_vld;
    word_d  = word_q;
    flags_d = flags_q;
    if (op_vld) begin
      word_d  = cvt_word;
      flags_d = cvt_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      word_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q   <= vld_d;
      word_q  <= word_d;
      flags_q <= flags_d;
    end
  end

  assign res_vld       = vld_q;
  assign res_word      = word_q;
  assign flg_invalid   = flags_q.invalid;
  assign flg_overflow  = flags_q.overflow;
  assign flg_underflow = flags_q.underflow;
  assign flg_inexact   = flags_q.inexact;

  assert_vld_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> res_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> !res_vld);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> $stable(res_word) && $stable(flg_inexact));
  assert_dflt_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && dflt_nan && (op_word[SRC_W-2 -: SRC_EW] == '1) && (op_word[SRC_FW-1:0] != '0)
    |=> res_word == DFLT_NAN_WORD);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && flg_overflow |-> flg_inexact && res_word[DST_W-2:0] == {{DST_EW{1'b1}}, {DST_FW{1'b0}}});
  assert_underflow_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && flg_underflow |-> flg_inexact && !flg_overflow);
  assert_src_sub_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && (op_word[SRC_W-2 -: SRC_EW] == '0) && (op_word[SRC_FW-1:0] != '0)
    |=> res_word[DST_W-2:0] == '0 && flg_underflow);
  assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld && (op_word[SRC_W-2:0] == '0) |=> res_word[DST_W-2:0] == '0 && !flg_inexact);
endmodule

// File: tb/f32_to_f16_narrow_tb_top.sv
module f32_to_f16_narrow_tb_top;
  logic        clk;
  logic        rst_n;
  logic        op_vld;
  logic [31:0] op_word;
  logic        dflt_nan;
  logic        res_vld;
  logic [15:0] res_word;
  logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  f32_to_f16_narrow dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_vld        (op_vld),
    .op_word       (op_word),
    .dflt_nan      (dflt_nan),
    .res_vld       (res_vld),
    .res_word      (res_word),
    .flg_invalid   (flg_invalid),
    .flg_overflow  (flg_overflow),
    .flg_underflow (flg_underflow),
    .flg_inexact   (flg_inexact)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference: {invalid, overflow, underflow, inexact, word16}
  function automatic logic [19:0] ref_cvt(input logic [31:0] x, input logic dn);
    logic        s;
    int          e;
    logic [22:0] f;
    longint      m, qv, rem, half, rv;
    int          ee, q, k, bexp;
    logic        up, inx;
    logic [15:0] w;
    s = x[31];
    e = int'(x[30:23]);
    f = x[22:0];
    if (e == 255) begin
      if (f == 0) return {4'b0000, s, 15'h7C00};
      if (dn) w = 16'h7E00;
      else    w = {s, 5'h1F, f[22:13]} | 16'h0200;
      return {!f[22], 3'b000, w};
    end
    if (e == 0) begin
      if (f == 0) return {4'b0000, s, 15'h0000};
      return {4'b0011, s, 15'h0000};
    end
    ee = e - 127;
    m  = longint'({1'b1, f});
    q  = (ee < -14) ? -24 : ee - 10;
    k  = q - (ee - 23);
    if (k >= 40) begin
      qv = 0; rem = m; up = 1'b0;
    end else begin
      qv   = m >> k;
      rem  = m - (qv << k);
      half = longint'(1) << (k - 1);
      up   = (rem > half) || (rem == half && qv[0]);
    end
    rv  = qv + (up ? 1 : 0);
    inx = (rem != 0);
    if (ee >= -14) begin
      bexp = ee + 15;
      if (rv == 2048) begin rv = 1024; bexp = bexp + 1; end
      if (bexp >= 31) return {4'b0101, s, 15'h7C00};
      w = {s, 5'(bexp), 10'(rv - 1024)};
      return {2'b00, 1'b0, inx, w};
    end
    w = {s, 15'(rv)};
    return {2'b00, inx, inx, w};
  endfunction

  function automatic logic [19:0] dut_out();
    return {flg_invalid, flg_overflow, flg_underflow, flg_inexact, res_word};
  endfunction

  task automatic cmp(input logic [19:0] act, input logic [19:0] exp, input string tag,
                     input logic [31:0] x);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%h act=%h exp=%h", tag, x, act, exp);
    end
  endtask

  // drive one operand at a falling edge, sample one cycle later at a falling edge
  task automatic apply(input logic [31:0] x, input logic dn, output logic [19:0] act);
    op_word  = x;
    dflt_nan = dn;
    op_vld   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_vld = 1'b0;
    checks++;
    if (res_vld !== 1'b1) begin
      errors++;
      $display("FAIL R1 res_vld act=%b exp=1", res_vld);
    end
    act = dut_out();
  endtask

  task automatic run_exp(input logic [31:0] x, input logic dn, input logic [19:0] exp,
                         input string tag);
    logic [19:0] act;
    apply(x, dn, act);
    cmp(act, exp, tag, x);
  endtask

  task automatic run_ref(input logic [31:0] x, input logic dn, input string tag);
    logic [19:0] act;
    apply(x, dn, act);
    cmp(act, ref_cvt(x, dn), tag, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    op_vld = 1'b0; op_word = '0; dflt_nan = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset res_vld act=%b exp=0", res_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases; flags = {inv,ovf,unf,inx}
    run_exp(32'h3F800000, 0, {4'b0000, 16'h3C00}, "R6 one");
    run_exp(32'h3F801000, 0, {4'b0001, 16'h3C00}, "R6 tie to even down");
    run_exp(32'h3F803000, 0, {4'b0001, 16'h3C02}, "R6 tie to even up");
    run_exp(32'h3FFFF000, 0, {4'b0001, 16'h4000}, "R7 carry into exponent");
    run_exp(32'h477FE000, 0, {4'b0000, 16'h7BFF}, "R8 max finite exact");
    run_exp(32'h477FF000, 0, {4'b0101, 16'h7C00}, "R8 R7 carry to infinity");
    run_exp(32'hC77FEFFF, 0, {4'b0001, 16'hFBFF}, "R8 just below rounds down");
    run_exp(32'h7F7FFFFF, 1, {4'b0101, 16'h7C00}, "R8 huge");
    run_exp(32'h38800000, 0, {4'b0000, 16'h0400}, "R9 min normal");
    run_exp(32'h387FF000, 0, {4'b0011, 16'h0400}, "R10 R9 largest subnormal carries");
    run_exp(32'h33800000, 0, {4'b0000, 16'h0001}, "R10 min subnormal exact");
    run_exp(32'h34400000, 0, {4'b0000, 16'h0003}, "R9 exact subnormal");
    run_exp(32'h33C00000, 0, {4'b0011, 16'h0002}, "R9 subnormal tie up");
    run_exp(32'hB3000001, 0, {4'b0011, 16'h8001}, "R9 sticky past guard");
    run_exp(32'h33000000, 0, {4'b0011, 16'h0000}, "R11 half ulp tie to zero");
    run_exp(32'h8D000000, 0, {4'b0011, 16'h8000}, "R11 far below");
    run_exp(32'h80000000, 0, {4'b0000, 16'h8000}, "R2 negative zero");
    run_exp(32'hFF800000, 0, {4'b0000, 16'hFC00}, "R2 negative infinity");
    run_exp(32'h7F800000, 1, {4'b0000, 16'h7C00}, "R2 infinity with dn");
    run_exp(32'h00000001, 0, {4'b0011, 16'h0000}, "R12 min source subnormal");
    run_exp(32'h80400000, 0, {4'b0011, 16'h8000}, "R12 negative source subnormal");
    run_exp(32'h7FC12345, 0, {4'b0000, 16'h7E09}, "R4 quiet nan payload");
    run_exp(32'hFF812345, 0, {4'b1000, 16'hFE09}, "R4 R5 signalling nan payload");
    run_exp(32'hFF812345, 1, {4'b1000, 16'h7E00}, "R3 R5 signalling nan default");
    run_exp(32'h7FC00001, 1, {4'b0000, 16'h7E00}, "R3 quiet nan default");

    // R1: idle cycle leaves outputs untouched though the operand changes
    run_ref(32'h40490FDB, 0, "R6 pi");
    held    = dut_out();
    op_word = 32'hFF812345;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || dut_out() !== held) begin
      errors++;
      $display("FAIL R1 hold act=%b/%h exp=0/%h", res_vld, dut_out(), held);
    end

    // constrained random, fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      logic [2:0]  sel;
      x   = $urandom;
      sel = 3'($urandom % 5);
      case (sel)
        3'd1: x[30:23] = 8'(96 + $urandom % 52);
        3'd2: begin
          x[30:23] = 8'(96 + $urandom % 52);
          x[12:0]  = ($urandom % 2) ? 13'h1000 : 13'h0FFF;
        end
        3'd3: begin
          x[30:23] = 8'(100 + $urandom % 14);
          if ($urandom % 2) x[22:0] = 23'h7FF000 | 23'($urandom % 2);
        end
        3'd4: x[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
        default: ;
      endcase
      run_ref(x, 1'($urandom % 2), "R6 R9 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule